// File: doc/BRIEF.md
# Mode-Selected Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit with a width set by a parameter. One adder produces every arithmetic result. Before the adder, each bit of the second operand goes through select-driven input logic: `y = (b & sel[0]) | (~b & sel[1])`. The adder then forms `a + y + cin`. Two select bits and a carry-in therefore give eight arithmetic functions: transfer, increment, add, add plus one, add with complement, subtract, decrement and transfer again.

A mode bit chooses between the adder and a bitwise logic stage. In logic mode, the same two select bits choose AND, OR, XOR or complement of `a`. In that mode the carry-in has no effect, and both flags are held low. A datapath control word drives the mode, select and carry-in inputs directly. The result drives the function-select mux of the surrounding datapath.

Top module: `alu_mode_sel`

## Requirements
- R1: With mode_i=0 and sel_i=2'b00, result_o equals a_i + cin_i (modulo 2^WIDTH).
- R2: With mode_i=0 and sel_i=2'b01, result_o equals a_i + b_i + cin_i; the code mode=0, sel=01, cin=0 is plain addition.
- R3: With mode_i=0 and sel_i=2'b10, result_o equals a_i + ~b_i + cin_i, i.e. a-b-1, or a-b when cin_i=1.
- R4: With mode_i=0 and sel_i=2'b11, result_o equals a_i + all-ones + cin_i, i.e. a-1, or a when cin_i=1.
- R5: In arithmetic mode, cout_o is bit WIDTH of the unsigned sum a_i + y + cin_i.
- R6: In arithmetic mode, ovf_o is 1 exactly when the two's-complement sum a_i + y + cin_i falls outside the signed WIDTH-bit range.
- R7: With mode_i=1 and sel_i=2'b00, result_o equals a_i & b_i.
- R8: With mode_i=1 and sel_i=2'b01, result_o equals a_i | b_i.
- R9: With mode_i=1 and sel_i=2'b10, result_o equals a_i ^ b_i.
- R10: With mode_i=1 and sel_i=2'b11, result_o equals ~a_i.
- R11: With mode_i=1, cout_o and ovf_o are 0, and cin_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand, shaped by the input logic in arithmetic mode |
| mode_i | input | 1 | 0 = arithmetic, 1 = logic |
| sel_i | input | 2 | Function select within the mode |
| cin_i | input | 1 | Adder carry-in, used only in arithmetic mode |
| result_o | output | WIDTH | Selected result |
| cout_o | output | 1 | Adder carry-out, 0 in logic mode |
| ovf_o | output | 1 | Signed overflow, 0 in logic mode |

## Verification
Immediate assertions watch several things whenever the inputs settle. They confirm that the operand shaping passes or inverts `b` for the two middle select codes. They confirm that the overflow flag agrees with the operand and result sign bits. They confirm that a zero operand with no carry-in cannot carry out, that the complement operation inverts every bit, and that both flags stay low in logic mode. Only the bench's scenarios can show the full value of each of the eight arithmetic functions and four logic functions against an independent model. The same holds for the boundary operands where the sum wraps or crosses the signed limits, and for the lack of any effect of carry-in in logic mode.

// File: rtl/alu_ms_pkg.sv
package alu_ms_pkg;
  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_OR  = 2'b01,
    LOP_XOR = 2'b10,
    LOP_NOT = 2'b11
  } logic_op_e;
endpackage

// File: rtl/alu_b_shape.sv
module alu_b_shape #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] y_o
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign y_o[i] = (b_i[i] & sel_i[0]) | (~b_i[i] & sel_i[1]);
    end
  endgenerate

  always_comb begin
    if (!$isunknown({b_i, sel_i, y_o})) begin
      if (sel_i == 2'b01) p_y_pass_r2: assert (y_o == b_i) else $error("y not b");
      if (sel_i == 2'b10) p_y_inv_r3: assert (y_o == ~b_i) else $error("y not ~b");
    end
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  logic [WIDTH:0] c;
  assign c[0] = cin_i;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_fa
      assign sum_o[i] = a_i[i] ^ y_i[i] ^ c[i];
      assign c[i+1]   = (a_i[i] & y_i[i]) | (c[i] & (a_i[i] ^ y_i[i]));
    end
  endgenerate

  assign cout_o = c[WIDTH];
  assign ovf_o  = c[WIDTH] ^ c[WIDTH-1];

  always_comb begin
    if (!$isunknown({a_i, y_i, cin_i, sum_o, ovf_o, cout_o})) begin
      p_ovf_sign_r6: assert (ovf_o == ((a_i[WIDTH-1] == y_i[WIDTH-1]) &&
                                       (sum_o[WIDTH-1] != a_i[WIDTH-1])))
        else $error("overflow disagrees with signs");
      if (y_i == '0 && !cin_i)
        p_no_carry_r5: assert (!cout_o) else $error("carry from a+0");
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_ms_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic_op_e        op_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      LOP_AND: res_o = a_i & b_i;
      LOP_OR:  res_o = a_i | b_i;
      LOP_XOR: res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end

  always_comb begin
    if (!$isunknown({a_i, op_i, res_o}) && op_i == LOP_NOT)
      p_not_all_r10: assert ((res_o ^ a_i) == '1) else $error("not-a mismatch");
  end
endmodule

// File: rtl/alu_mode_sel.sv
module alu_mode_sel
  import alu_ms_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             mode_i,
  input  logic [1:0]       sel_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] result_o,
  output logic             cout_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] y, arith_res, logic_res;
  logic             add_c, add_v;

  alu_b_shape #(.WIDTH(WIDTH)) i_b_shape (
    .b_i(b_i), .sel_i(sel_i), .y_o(y)
  );

  alu_adder #(.WIDTH(WIDTH)) i_adder (
    .a_i(a_i), .y_i(y), .cin_i(cin_i),
    .sum_o(arith_res), .cout_o(add_c), .ovf_o(add_v)
  );

  alu_logic #(.WIDTH(WIDTH)) i_logic (
    .a_i(a_i), .b_i(b_i), .op_i(logic_op_e'(sel_i)), .res_o(logic_res)
  );

  assign result_o = mode_i ? logic_res : arith_res;
  assign cout_o   = mode_i ? 1'b0 : add_c;
  assign ovf_o    = mode_i ? 1'b0 : add_v;

  always_comb begin
    if (!$isunknown({mode_i, cout_o, ovf_o}) && mode_i)
      p_flags_low_r11: assert (!cout_o && !ovf_o) else $error("flags in logic mode");
  end
endmodule

// File: tb/test_alu_mode_sel.sv
module test_alu_mode_sel;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic         mode, cin, cout, ovf;
  logic [1:0]   sel;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  alu_mode_sel #(.WIDTH(W)) i_alu_mode_sel (
    .a_i(a), .b_i(b), .mode_i(mode), .sel_i(sel), .cin_i(cin),
    .result_o(res), .cout_o(cout), .ovf_o(ovf)
  );

  function automatic string req_of(logic m, logic [1:0] s);
    if (!m) case (s) 2'b00: return "R1"; 2'b01: return "R2"; 2'b10: return "R3"; default: return "R4"; endcase
    case (s) 2'b00: return "R7"; 2'b01: return "R8"; 2'b10: return "R9"; default: return "R10"; endcase
  endfunction

  function automatic logic [W+1:0] model(logic [W-1:0] ma, logic [W-1:0] mb,
                                         logic m, logic [1:0] s, logic c);
    logic [W-1:0] yy, r;
    logic [W:0]   u;
    int           sv;
    logic         v;
    if (m) begin
      case (s)
        2'b00: r = ma & mb;
        2'b01: r = ma | mb;
        2'b10: r = ma ^ mb;
        default: r = ~ma;
      endcase
      return {r, 1'b0, 1'b0};
    end
    case (s)
      2'b00: yy = '0;
      2'b01: yy = mb;
      2'b10: yy = ~mb;
      default: yy = '1;
    endcase
    u  = {1'b0, ma} + {1'b0, yy} + {{W{1'b0}}, c};
    sv = int'($signed(ma)) + int'($signed(yy)) + int'(c);
    v  = (sv > (2**(W-1) - 1)) || (sv < -(2**(W-1)));
    return {u[W-1:0], u[W], v};
  endfunction

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(logic [W-1:0] ta, logic [W-1:0] tb_, logic m, logic [1:0] s, logic c);
    logic [W+1:0] e;
    @(negedge clk);
    a = ta; b = tb_; mode = m; sel = s; cin = c;
    #1;
    e = model(ta, tb_, m, s, c);
    check(req_of(m, s), "result", res, e[W+1:2]);
    check(m ? "R11" : "R5", "cout", W'(cout), W'(e[1]));
    check(m ? "R11" : "R6", "ovf", W'(ovf), W'(e[0]));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r0;
    void'($urandom(32'd1207));
    a = '0; b = '0; mode = 0; sel = 0; cin = 0;
    // reset-like idle state: all zero inputs
    run('0, '0, 0, 2'b00, 0);
    // R2 plain add code 0010 and wrap
    run(8'h12, 8'h34, 0, 2'b01, 0);
    run(8'hFF, 8'h01, 0, 2'b01, 0);
    run(8'h7F, 8'h01, 0, 2'b01, 0);
    run(8'h80, 8'h80, 0, 2'b01, 1);
    // R1 increment to wrap
    run(8'hFF, 8'h55, 0, 2'b00, 1);
    run(8'h7F, 8'h00, 0, 2'b00, 1);
    // R3 subtract boundary
    run(8'h80, 8'h01, 0, 2'b10, 1);
    run(8'h05, 8'h05, 0, 2'b10, 1);
    run(8'h05, 8'h05, 0, 2'b10, 0);
    // R4 decrement and transfer
    run(8'h00, 8'hAA, 0, 2'b11, 0);
    run(8'h80, 8'hAA, 0, 2'b11, 0);
    run(8'h3C, 8'hAA, 0, 2'b11, 1);
    // R7..R10 logic ops
    for (int s = 0; s < 4; s++) run(8'hF0, 8'h3C, 1, 2'(s), 0);
    // R11 cin has no effect in logic mode
    for (int s = 0; s < 4; s++) begin
      run(8'hA5, 8'h5A, 1, 2'(s), 0);
      r0 = res;
      run(8'hA5, 8'h5A, 1, 2'(s), 1);
      check("R11", "cin ignored", res, r0);
    end
    for (int k = 0; k < 3000; k++)
      run(W'($urandom), W'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule